// File: doc/BRIEF.md
# Serial Memory Clock Divider

This block derives the serial clock for a quad-SPI pseudo-SRAM port from the system bus clock. A programmable integer ratio sets the serial clock period. While the transfer sequencer holds the run input high, the block produces a continuous clock whose period is the divider value plus one bus cycles. When the run input is low, the clock rests low.

Alongside the clock, the block drives two single-cycle strobes, one for each serial clock edge. The shift and sample logic uses these strobes so that it never has to detect edges on the serial clock itself. The block copies the divider value only when a transfer starts, so software may rewrite it at any time.

Older pseudo-SRAM parts expect one more clock pulse after chip-select is released. The block therefore drives the serial clock high for exactly one bus cycle after it sees chip-select rise.

Top module: `sqclk_divgen`

## Requirements
- R1: While `run_i` is high, `sclk_o` repeats with a period of `div_i + 1` bus cycles. Its first high cycle starts at the clock edge where `run_i` is first sampled high.
- R2: A `div_i` of zero is clamped to one, so the period is two bus cycles. The clock never stops or sticks while running.
- R3: When the period is odd (even `div_i`), the high phase is `(div_i + 2) / 2` bus cycles. This is one cycle longer than the low phase.
- R4: When the period is even (odd `div_i`), the high and low phases each last `(div_i + 1) / 2` bus cycles.
- R5: When `csn_i` rises while `run_i` is low, `sclk_o` is high for exactly the next bus cycle and then returns low.
- R6: When `run_i` is low and no deselect pulse is due, `sclk_o` is low from the next cycle on.
- R7: `rise_o` is high exactly in the cycles where `sclk_o` is high after being low. `fall_o` is high exactly in the cycles where `sclk_o` is low after being high. The two strobes are never high together.
- R8: The block captures `div_i` at the start of each transfer. A change to `div_i` during a transfer does not alter the running clock.
- R9: After reset, `sclk_o`, `rise_o` and `fall_o` are low. Releasing reset with `csn_i` high produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | W | Divider value; period is div_i+1 bus cycles |
| run_i | input | 1 | Transfer active, from the sequencer |
| csn_i | input | 1 | Chip-select state, active low |
| sclk_o | output | 1 | Serial clock |
| rise_o | output | 1 | High in the first cycle of each high phase |
| fall_o | output | 1 | High in the first cycle of each low phase |

## Verification
The bench sweeps the divider value over the illegal zero, odd values and even values, and compares the high and low phase lengths cycle by cycle. A design that split an odd period the wrong way, or let zero freeze the counter, would show up as shifted edges.

It rewrites the divider in the middle of a transfer. A design that did not latch the value would change its period on the spot.

It also checks the single pulse after deselect, including its width and its strobes. Missing the pulse, or stretching it to two cycles, breaks the expected pattern. Finally, it holds the block idle while the inputs change, to catch any stray toggles.

// File: rtl/sqclk_divgen.sv
module sqclk_divgen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_i,
  input  logic         run_i,
  input  logic         csn_i,
  output logic         sclk_o,
  output logic         rise_o,
  output logic         fall_o
);

  logic         active;
  logic         csn_q;
  logic [W-1:0] div_q;
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_n;
  logic [W:0]   hi_len;
  logic         cs_rise;

  assign cs_rise = csn_i & ~csn_q;
  assign hi_len  = ({1'b0, div_q} + (W+1)'(2)) >> 1;
  assign cnt_n   = (cnt == div_q) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      csn_q  <= 1'b1;
      div_q  <= W'(1);
      cnt    <= '0;
      sclk_o <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      csn_q <= csn_i;
      if (run_i && !active) begin
        active <= 1'b1;
        div_q  <= (div_i == '0) ? W'(1) : div_i;
        cnt    <= '0;
        sclk_o <= 1'b1;
        rise_o <= ~sclk_o;
        fall_o <= 1'b0;
      end else if (run_i) begin
        cnt    <= cnt_n;
        sclk_o <= {1'b0, cnt_n} < hi_len;
        rise_o <= (cnt_n == '0);
        fall_o <= ({1'b0, cnt_n} == hi_len);
      end else if (cs_rise) begin
        active <= 1'b0;
        sclk_o <= 1'b1;
        rise_o <= ~sclk_o;
        fall_o <= 1'b0;
      end else begin
        active <= 1'b0;
        sclk_o <= 1'b0;
        rise_o <= 1'b0;
        fall_o <= sclk_o;
      end
    end
  end

  a_r7_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (sclk_o && !$past(sclk_o)));
  a_r7_fall_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!sclk_o && $past(sclk_o)));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
  a_r2_no_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (div_q != '0));
  a_r5_pulse_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !run_i) |=> sclk_o);
  a_r5_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !run_i) ##1 (!run_i && !cs_rise) |=> !sclk_o);
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !cs_rise) |=> !sclk_o);
  a_r8_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && run_i) |=> $stable(div_q));

endmodule

// File: tb/sim_sqclk_divgen.sv
module sim_sqclk_divgen;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] div_i = 8'd3;
  logic run_i = 1'b0;
  logic csn_i = 1'b1;
  logic sclk_o, rise_o, fall_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sqclk_divgen #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .run_i(run_i), .csn_i(csn_i),
    .sclk_o(sclk_o), .rise_o(rise_o), .fall_o(fall_o)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t {sclk,rise,fall} actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Runs a transfer with divider d (expected effective e), optionally rewriting div mid-way
  task automatic run_transfer(input int d, input int e, input string req, input bit poke);
    int p, hi;
    p  = e + 1;
    hi = (e + 2) / 2;
    @(negedge clk);
    div_i = W'(d);
    csn_i = 1'b0;
    run_i = 1'b1;
    for (int j = 0; j < 3 * p; j++) begin
      @(negedge clk);
      chk(req, {sclk_o, rise_o, fall_o},
          {(j % p) < hi, (j % p) == 0, (j % p) == hi});
      if (poke && j == 1) div_i = 8'd1;
    end
    run_i = 1'b0;
    @(negedge clk);
    chk("R6 stop", {sclk_o, rise_o, fall_o}, {1'b0, 1'b0, ((3 * p - 1) % p) < hi});
    csn_i = 1'b1;
    @(negedge clk);
    chk("R5 pulse high", {sclk_o, rise_o, fall_o}, 3'b110);
    @(negedge clk);
    chk("R5 pulse end", {sclk_o, rise_o, fall_o}, 3'b001);
    @(negedge clk);
    chk("R6 idle", {sclk_o, rise_o, fall_o}, 3'b000);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R9 in reset", {sclk_o, rise_o, fall_o}, 3'b000);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 after reset", {sclk_o, rise_o, fall_o}, 3'b000);
    end
  endtask

  task automatic test_idle();
    @(negedge clk);
    csn_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      div_i = W'(k * 3);
      @(negedge clk);
      chk("R6 idle inputs moving", {sclk_o, rise_o, fall_o}, 3'b000);
    end
    csn_i = 1'b1;
    @(negedge clk);
    chk("R5 idle pulse", {sclk_o, rise_o, fall_o}, 3'b110);
    @(negedge clk);
    chk("R5 idle pulse end", {sclk_o, rise_o, fall_o}, 3'b001);
  endtask

  initial begin
    #800000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    run_transfer(1, 1, "R1 R4 div1", 1'b0);
    run_transfer(3, 3, "R1 R4 div3", 1'b0);
    run_transfer(7, 7, "R4 div7", 1'b0);
    run_transfer(2, 2, "R3 div2", 1'b0);
    run_transfer(4, 4, "R3 div4", 1'b0);
    run_transfer(0, 1, "R2 div0", 1'b0);
    run_transfer(5, 5, "R8 change mid-transfer", 1'b1);
    run_transfer(1, 1, "R8 new div next transfer", 1'b0);
    test_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule